// File: doc/BRIEF.md
# Selectively Depipelined Loop Engine

This block runs a fixed loop body in hardware. For every index i below a count n, it reads x from array A and y from array B, then reads D at index y. It then writes D[y] + x + y + (x-1)*(y-1) to array C at index x. Each pass through the body is one slow step. A slow step is a run of fast-clock substates: one request substate and one wait substate for each memory access, a settle window for the arithmetic, and a final store substate. The slow step ends only when every substate has finished, so its length is always a whole number of fast cycles. It varies with memory latency and back-pressure.

The arithmetic is a purely combinational chain. It is fed by the three load-receive registers and by the live-out index register, and no pipeline register sits inside it. The only state is the receive registers, the index and count latched at the block boundary, and the control states. Software gives a start pulse together with the count and the four word-indexed base addresses. The engine then drives one split-phase memory port and raises done for a single cycle after the exit block.

The request channel follows valid/ready rules. Once `mem_req_valid` is high, the address, write flag and write data stay unchanged until the cycle in which `mem_req_ready` is also high. The response channel also follows valid/ready rules. `mem_rsp_ready` is high only while the engine waits for a load result. The memory must hold `mem_rsp_valid` and its data until that handshake. At most one access is outstanding at any time.

Top module: `sdp_loop_engine`

## Requirements
- R1: After reset, and whenever the engine is not busy, `busy`, `done` and `mem_req_valid` are low.
- R2: Each iteration i issues exactly four requests in this order: a load from base_a+i, a load from base_b+i, a load from base_d+y, and then a store to base_c+x. `mem_req_write` is 1 only for the store.
- R3: The store data equals D[y]+x+y+(x-1)*(y-1) computed modulo 2^32, where the product is truncated to 32 bits. The received x, y and D[y] stay unchanged through the settle window.
- R4: After a load request is accepted, no further request is issued until its response has been taken. A late response stalls the substate sequence.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid, and its address, write flag and data do not change.
- R6: The store request is first presented exactly SETTLE_CYC+1 cycles after the cycle in which the D[y] response handshake occurs (2 cycles for the default SETTLE_CYC=2, giving 3).
- R7: The body runs exactly n times, with the index taking the values 0..n-1 in increasing order. n=1 gives a single iteration.
- R8: With n=0, no memory request is made, and done is high in the second cycle after the cycle in which start was sampled.
- R9: When n>0, done is high for exactly one cycle: the cycle that follows the handshake of the final store.
- R10: A start pulse received while busy has no effect on the sequence of requests or on the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| n_iter | input | AW | Iteration count |
| base_a | input | AW | Word base of array A |
| base_b | input | AW | Word base of array B |
| base_c | input | AW | Word base of array C |
| base_d | input | AW | Word base of array D |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle pulse after the exit block |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | DW | Store data |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_ready | output | 1 | Engine takes load data |
| mem_rsp_data | input | DW | Load data |

## Verification
The bench works against a memory model whose response latency and request back-pressure can be set. A design that issued the next request before a slow load returned would be caught by the outstanding-load check. A design that let the address or data change while the memory stalled would be caught by the hold check. The D[y] values are large so that the sum and the truncated product wrap, and a wrong width or a carry into the product shows up as bad store data. Repeated x values make later stores overwrite earlier ones, so stores that land out of order leave a wrong final C. The n=0 and n=1 runs expose off-by-one errors in the loop test. The settle-gap measurement catches a settle counter that is one cycle short or long. A second start pulse in the middle of a run would show up as extra requests or a second done.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [3:0] {
    F_IDLE,
    F_LD_A,
    F_WT_A,
    F_LD_B,
    F_WT_B,
    F_LD_D,
    F_WT_D,
    F_SETTLE,
    F_ST_C
  } fast_st_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ENTRY,
    S_BODY,
    S_EXIT
  } slow_st_e;

endpackage

// File: rtl/sdp_datapath.sv
// Combinational body arithmetic: no register inside the chain.
module sdp_datapath #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] y_val,
  input  logic [DW-1:0] dy_val,
  output logic [DW-1:0] store_val
);
  logic [DW-1:0] xm1, ym1, prod, lin;

  always_comb begin
    xm1       = x_val - DW'(1);
    ym1       = y_val - DW'(1);
    prod      = xm1 * ym1;
    lin       = dy_val + x_val + y_val;
    store_val = lin + prod;
  end
endmodule

// File: rtl/sdp_loop_test.sv
// Loop test and increment, evaluated in the body block itself.
module sdp_loop_test #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] count,
  output logic [AW-1:0] idx_next,
  output logic          again
);
  always_comb begin
    idx_next = idx + AW'(1);
    again    = (idx_next < count);
  end
endmodule

// File: rtl/sdp_fast_seq.sv
// Fast substate sequencer for one body block: split-phase memory accesses,
// receive registers, settle window and store.
module sdp_fast_seq
  import sdp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int SETTLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  input  logic [AW-1:0] base_d,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          blk_done,
  output logic          idle
);
  localparam int SCW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  fast_st_e       st_q;
  logic [DW-1:0]  x_q, y_q, dy_q;
  logic [SCW-1:0] cnt_q;
  logic [DW-1:0]  store_val;

  sdp_datapath #(.DW(DW)) u_dp (
    .x_val    (x_q),
    .y_val    (y_q),
    .dy_val   (dy_q),
    .store_val(store_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= F_IDLE;
      x_q   <= '0;
      y_q   <= '0;
      dy_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        F_IDLE:   if (go) st_q <= F_LD_A;
        F_LD_A:   if (req_ready) st_q <= F_WT_A;
        F_WT_A:   if (rsp_valid) begin
                    x_q  <= rsp_data;
                    st_q <= F_LD_B;
                  end
        F_LD_B:   if (req_ready) st_q <= F_WT_B;
        F_WT_B:   if (rsp_valid) begin
                    y_q  <= rsp_data;
                    st_q <= F_LD_D;
                  end
        F_LD_D:   if (req_ready) st_q <= F_WT_D;
        F_WT_D:   if (rsp_valid) begin
                    dy_q  <= rsp_data;
                    cnt_q <= SCW'(SETTLE_CYC - 1);
                    st_q  <= F_SETTLE;
                  end
        F_SETTLE: if (cnt_q == '0) st_q <= F_ST_C;
                  else cnt_q <= cnt_q - SCW'(1);
        F_ST_C:   if (req_ready) st_q <= F_IDLE;
        default:  st_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    rsp_ready = 1'b0;
    case (st_q)
      F_LD_A: begin req_valid = 1'b1; req_addr = base_a + idx; end
      F_LD_B: begin req_valid = 1'b1; req_addr = base_b + idx; end
      F_LD_D: begin req_valid = 1'b1; req_addr = base_d + AW'(y_q); end
      F_ST_C: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = base_c + AW'(x_q);
        req_wdata = store_val;
      end
      F_WT_A, F_WT_B, F_WT_D: rsp_ready = 1'b1;
      default: ;
    endcase
    blk_done = (st_q == F_ST_C) && req_ready;
    idle     = (st_q == F_IDLE);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_write) && $stable(req_wdata))
    else $error("request changed under back-pressure"); // R5

  AST_LOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_ready && !req_valid)
    else $error("request issued with a load outstanding"); // R4

  AST_STORE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_ST_C) && !$past(st_q == F_ST_C) |->
      $past(st_q == F_SETTLE) && ($past(cnt_q) == '0))
    else $error("store entered before settle window ended"); // R6

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_SETTLE) |=> $stable(x_q) && $stable(y_q) && $stable(dy_q))
    else $error("receive register moved during settle"); // R3
endmodule

// File: rtl/sdp_loop_engine.sv
// Slow-step control: entry block, repeated body block, exit block.
module sdp_loop_engine
  import sdp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int SETTLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] n_iter,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  input  logic [AW-1:0] base_d,
  output logic          busy,
  output logic          done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data
);
  slow_st_e      slow_q;
  logic [AW-1:0] i_q, n_q;
  logic [AW-1:0] ba_q, bb_q, bc_q, bd_q;
  logic [AW-1:0] i_next;
  logic          again;
  logic          go, blk_done, seq_idle;

  sdp_loop_test #(.AW(AW)) u_test (
    .idx     (i_q),
    .count   (n_q),
    .idx_next(i_next),
    .again   (again)
  );

  assign go = (slow_q == S_BODY) && seq_idle;

  sdp_fast_seq #(.DW(DW), .AW(AW), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .idx      (i_q),
    .base_a   (ba_q),
    .base_b   (bb_q),
    .base_c   (bc_q),
    .base_d   (bd_q),
    .req_valid(mem_req_valid),
    .req_ready(mem_req_ready),
    .req_write(mem_req_write),
    .req_addr (mem_req_addr),
    .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid),
    .rsp_ready(mem_rsp_ready),
    .rsp_data (mem_rsp_data),
    .blk_done (blk_done),
    .idle     (seq_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= S_IDLE;
      i_q    <= '0;
      n_q    <= '0;
      ba_q   <= '0;
      bb_q   <= '0;
      bc_q   <= '0;
      bd_q   <= '0;
    end else begin
      case (slow_q)
        S_IDLE: if (start) begin
          i_q    <= '0;
          n_q    <= n_iter;
          ba_q   <= base_a;
          bb_q   <= base_b;
          bc_q   <= base_c;
          bd_q   <= base_d;
          slow_q <= S_ENTRY;
        end
        S_ENTRY: slow_q <= (n_q == '0) ? S_EXIT : S_BODY;
        S_BODY: if (blk_done) begin
          i_q    <= i_next;
          slow_q <= again ? S_BODY : S_EXIT;
        end
        S_EXIT:  slow_q <= S_IDLE;
        default: slow_q <= S_IDLE;
      endcase
    end
  end

  assign busy = (slow_q != S_IDLE);
  assign done = (slow_q == S_EXIT);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle"); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid)
    else $error("request while idle"); // R1

  AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (n_q == '0) |-> !mem_req_valid)
    else $error("request with zero count"); // R8

  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (i_q < n_q))
    else $error("index past count"); // R7
endmodule

// File: tb/sdp_loop_engine_tb.sv
module sdp_loop_engine_tb;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int SETTLE = 2;
  localparam int BA = 0, BB = 32, BC = 128, BD = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] n_iter = '0;
  logic busy, done;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid, rsp_ready;
  logic [DW-1:0] rsp_data;

  always #4 clk = ~clk;

  sdp_loop_engine #(.DW(DW), .AW(AW), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_iter(n_iter),
    .base_a(AW'(BA)), .base_b(AW'(BB)), .base_c(AW'(BC)), .base_d(AW'(BD)),
    .busy(busy), .done(done),
    .mem_req_valid(req_valid), .mem_req_ready(req_ready),
    .mem_req_write(req_write), .mem_req_addr(req_addr),
    .mem_req_wdata(req_wdata), .mem_rsp_valid(rsp_valid),
    .mem_rsp_ready(rsp_ready), .mem_rsp_data(rsp_data)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] mem [0:255];

  // memory model state
  int cyc = 0;
  int rsp_lat = 0;
  int bp_mode = 0;
  int lat_cnt = 0;
  bit pend = 0;
  logic [DW-1:0] pend_data;
  bit p_valid = 0, p_ready = 0, p_write = 0, p_rvalid = 0, p_rready = 0;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  int log_n = 0;
  logic [AW-1:0] log_addr [0:127];
  bit            log_wr   [0:127];
  logic [DW-1:0] log_data [0:127];
  int hold_bad = 0, ost_bad = 0, gap_bad = 0, gap_seen = 0;
  int last_rsp_cyc = 0, st_acc_cyc = 0, done_cnt = 0, done_cyc = 0;
  bit st_seen = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : mem_model
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (p_rvalid && p_rready) begin
        pend = 0;
        last_rsp_cyc = cyc - 1;
      end
      if (p_valid && p_ready) begin
        if (log_n < 128) begin
          log_addr[log_n] = p_addr;
          log_wr[log_n]   = p_write;
          log_data[log_n] = p_wdata;
        end
        log_n++;
        if (p_write) begin
          mem[p_addr[7:0]] = p_wdata;
          st_acc_cyc = cyc - 1;
          st_seen = 0;
        end else begin
          pend = 1;
          pend_data = mem[p_addr[7:0]];
          lat_cnt = rsp_lat;
        end
      end
      if (p_valid && !p_ready &&
          !(req_valid && req_addr == p_addr && req_write == p_write && req_wdata == p_wdata))
        hold_bad++;
      if (pend && req_valid) ost_bad++;
      if (req_valid && req_write && !st_seen) begin
        st_seen = 1;
        gap_seen++;
        if (cyc - last_rsp_cyc != SETTLE + 1) gap_bad++;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
      if (pend && lat_cnt == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = pend_data;
      end else begin
        if (pend) lat_cnt--;
        rsp_valid = 1'b0;
        rsp_data  = '0;
      end
      case (bp_mode)
        1:       req_ready = (cyc % 3 == 0);
        default: req_ready = 1'b1;
      endcase
      p_valid = req_valid; p_ready = req_ready; p_write = req_write;
      p_addr = req_addr; p_wdata = req_wdata;
      p_rvalid = rsp_valid; p_rready = rsp_ready;
    end
  end

  task automatic fill_mem(input int seed);
    for (int k = 0; k < 256; k++) mem[k] = '0;
    for (int k = 0; k < 32; k++) begin
      mem[BA + k] = DW'((k * 7 + seed) % 16);
      mem[BB + k] = DW'((k * 5 + seed * 3 + 1) % 16);
    end
    for (int k = 0; k < 16; k++)
      mem[BD + k] = 32'hF000_0000 + DW'(k * 32'h0123_4567) + DW'(seed);
  endtask

  // run one job; extra_start pulses start again mid-run
  task automatic run_job(input int n, input int lat, input int bp, input bit extra_start,
                         input string tag);
    logic [DW-1:0] ref_mem [0:255];
    int start_cyc, wait_cnt, lg;
    logic [DW-1:0] x, y, v;
    for (int k = 0; k < 256; k++) ref_mem[k] = mem[k];
    rsp_lat = lat; bp_mode = bp;
    @(negedge clk); #1;
    log_n = 0; hold_bad = 0; ost_bad = 0; gap_bad = 0; gap_seen = 0; done_cnt = 0;
    n_iter = AW'(n);
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk); #1;
    start = 1'b0;
    wait_cnt = 0;
    while (done_cnt == 0 && wait_cnt < 20000) begin
      if (extra_start && wait_cnt == 5) start = 1'b1;
      else start = 1'b0;
      @(negedge clk); #1;
      wait_cnt++;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(done_cnt == 1, {tag, " R9/R10 done count"}, done_cnt, 1);
    chk(log_n == 4 * n, {tag, " R7 request count"}, log_n, 4 * n);
    lg = 0;
    for (int i = 0; i < n && lg + 3 < log_n; i++) begin
      x = ref_mem[BA + i];
      y = ref_mem[BB + i];
      v = ref_mem[BD + y[7:0]] + x + y + (x - 1) * (y - 1);
      chk(log_addr[lg] == AW'(BA + i) && !log_wr[lg], {tag, " R2 load A addr"},
          log_addr[lg], BA + i);
      chk(log_addr[lg+1] == AW'(BB + i) && !log_wr[lg+1], {tag, " R2 load B addr"},
          log_addr[lg+1], BB + i);
      chk(log_addr[lg+2] == AW'(BD) + AW'(y) && !log_wr[lg+2], {tag, " R2 load D addr"},
          log_addr[lg+2], BD + y);
      chk(log_addr[lg+3] == AW'(BC) + AW'(x) && log_wr[lg+3], {tag, " R2 store C addr"},
          log_addr[lg+3], BC + x);
      chk(log_data[lg+3] == v, {tag, " R3 store data"}, log_data[lg+3], v);
      ref_mem[BC + x[7:0]] = v;
      lg += 4;
    end
    for (int k = 0; k < 16; k++)
      chk(mem[BC + k] == ref_mem[BC + k], {tag, " R3/R7 final C"}, mem[BC + k], ref_mem[BC + k]);
    chk(hold_bad == 0, {tag, " R5 hold under back-pressure"}, hold_bad, 0);
    chk(ost_bad == 0, {tag, " R4 single outstanding"}, ost_bad, 0);
    chk(gap_bad == 0 && gap_seen == n, {tag, " R6 settle gap"}, gap_bad, 0);
    if (n == 0)
      chk(done_cyc == start_cyc + 2, {tag, " R8 done timing"}, done_cyc, start_cyc + 2);
    else
      chk(done_cyc == st_acc_cyc + 1, {tag, " R9 done timing"}, done_cyc, st_acc_cyc + 1);
    chk(!busy && !req_valid, {tag, " R1 idle after run"}, busy, 0);
  endtask

  task automatic test_reset;
    #1;
    chk(!busy && !done && !req_valid, "R1 reset outputs", {busy, done, req_valid}, 0);
  endtask

  task automatic test_basic;    fill_mem(3); run_job(6, 0, 0, 0, "basic");   endtask
  task automatic test_single;   fill_mem(5); run_job(1, 0, 0, 0, "n1");      endtask
  task automatic test_zero;     fill_mem(7); run_job(0, 0, 0, 0, "n0 R8");   endtask
  task automatic test_late;     fill_mem(9); run_job(5, 4, 0, 0, "late R4"); endtask
  task automatic test_backpr;   fill_mem(2); run_job(7, 1, 1, 0, "bp R5");   endtask
  task automatic test_restart;  fill_mem(4); run_job(4, 2, 0, 1, "R10 start"); endtask
  task automatic test_long;     fill_mem(6); run_job(20, 0, 1, 0, "long R7"); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_basic();
    test_single();
    test_zero();
    test_late();
    test_backpr();
    test_restart();
    test_long();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule